// File: doc/BRIEF.md
# Write-Protect and Power-Down Command Gate

This block sits between a stream of decoded disk-style commands and the engine that executes them. A single active-low control pin has one of two roles, and a host configuration command picks the role. In write-protect mode, an asserted pin makes the gate refuse every command that would change or erase stored data. The gate answers the refused command itself with an invalid-command status. All other commands pass through to the executor.

In power-down mode, an asserted pin lets the command in flight finish. The gate then parks in a standby state and drops every later command. The role choice is held in a register that no reset clears. Only a power-on or hardware reset brings the gate out of standby, and it stays out only if the pin has been released.

The pin passes through a two-flop synchronizer. Write protection is judged once, at the cycle a command is accepted, so a pin change during a running command never aborts that command.

Top module: `wpgate_top`

## Requirements
- R1: In write-protect mode with the pin low, each of opcodes C0h, 50h, CAh, 32h, C5h, CDh, 30h, 31h, 38h and 3Ch is refused. No issue pulse is produced, and one cycle after acceptance statusReg reads 51h and errorReg reads 04h.
- R2: Any opcode outside that list, other than the configuration opcode (default 8Bh), is forwarded whatever the pin level. execIssue is high for exactly one cycle, one cycle after acceptance, with execOpcode equal to the accepted opcode.
- R3: In write-protect mode with the pin high, the destructive opcodes are forwarded like any other command.
- R4: The configuration opcode never reaches the executor. Bit CFG_SEL_BIT (default 0) of cmdFeature selects the role: 1 means power-down and 0 means write-protect. One cycle later status reads 50h and error reads 00h.
- R5: The selected role is unchanged by power-on reset and by hardware reset.
- R6: While a forwarded command runs, statusReg reads 80h. One cycle after execDone, statusReg reads 50h and errorReg reads 00h. cmdReady is low whenever execBusy is high.
- R7: In power-down mode, a pin asserted during a running command does not end that command early. lockedOut rises in the same cycle that the completion status appears, and it then stays high.
- R8: While lockedOut is high, cmdReady is low and no command produces an issue pulse.
- R9: A reset with the pin high leaves lockedOut low. A reset in power-down mode with the pin still low locks the gate again, one cycle after reset is released.
- R10: After reset with the pin high, statusReg is 50h, errorReg is 00h, execIssue is 0 and cmdReady is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| porRstN | input | 1 | Power-on reset, active low |
| hwRstN | input | 1 | Hardware reset, active low |
| pinN | input | 1 | Shared protect / power-down pin, active low, asynchronous |
| cmdValid | input | 1 | Command present this cycle |
| cmdOpcode | input | 8 | Command opcode |
| cmdFeature | input | 8 | Command argument; carries the role select for the configuration command |
| cmdReady | output | 1 | Gate will accept a command this cycle |
| execIssue | output | 1 | One-cycle start pulse to the executor |
| execOpcode | output | 8 | Opcode handed to the executor |
| execBusy | input | 1 | Executor is working |
| execDone | input | 1 | Executor finished the current command |
| statusReg | output | 8 | Status register value |
| errorReg | output | 8 | Error register value |
| lockedOut | output | 1 | Gate is in power-down standby |

## Verification
The write-protect decision is tried with every destructive opcode under a low pin and under a high pin. This separates a wrong list entry from a wrong pin polarity. Random opcodes with random pin levels and random executor delays check that non-destructive traffic is never touched. Reset sequences run in both roles, which shows that the role survives both resets. The power-down role is tried by dropping the pin in the middle of a command, by locking while idle, and by resetting with the pin still low. These cases separate a premature abort, a lost lock and a false unlock.

// File: rtl/wpgate_pkg.sv
package wpgate_pkg;
  localparam int OP_W = 8;
  localparam int REG_W = 8;

  localparam logic [REG_W-1:0] STAT_READY  = 8'h50;
  localparam logic [REG_W-1:0] STAT_BUSY   = 8'h80;
  localparam logic [REG_W-1:0] STAT_REJECT = 8'h51;
  localparam logic [REG_W-1:0] ERR_NONE    = 8'h00;
  localparam logic [REG_W-1:0] ERR_ABORT   = 8'h04;

  typedef enum logic [1:0] {ST_IDLE, ST_EXEC, ST_LOCK} gateState_t;

  typedef struct packed {
    logic issue;
    logic setBusy;
    logic setOk;
    logic setReject;
    logic loadMode;
  } gateStrobe_t;

  function automatic logic isDestructive(input logic [OP_W-1:0] op);
    case (op)
      8'h30, 8'h31, 8'h32, 8'h38, 8'h3C,
      8'h50, 8'hC0, 8'hC5, 8'hCA, 8'hCD: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/wpgate_dp.sv
module wpgate_dp
  import wpgate_pkg::*;
#(
  parameter int CFG_SEL_BIT = 0,
  parameter bit MODE_INIT = 1'b0,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              pinN,
  input  logic [OP_W-1:0]   cmdOpcode,
  input  logic [OP_W-1:0]   cmdFeature,
  input  gateStrobe_t       strb,
  output logic              pinAsserted,
  output logic              modePd,
  output logic              destructive,
  output logic              execIssue,
  output logic [OP_W-1:0]   execOpcode,
  output logic [REG_W-1:0]  statusReg,
  output logic [REG_W-1:0]  errorReg
);
  localparam logic [OP_W-1:0] SEL_MASK = OP_W'(1) << CFG_SEL_BIT;

  // Pin synchronizer, free running so it already tracks the pin when reset lifts
  logic [SYNC_STAGES-1:0] syncQ = '1;
  generate
    if (SYNC_STAGES == 1) begin : g_one
      always_ff @(posedge clk) syncQ <= pinN;
    end else begin : g_chain
      always_ff @(posedge clk) syncQ <= {syncQ[SYNC_STAGES-2:0], pinN};
    end
  endgenerate
  assign pinAsserted = ~syncQ[SYNC_STAGES-1];

  // Role register: deliberately outside every reset
  logic modeQ = MODE_INIT;
  always_ff @(posedge clk) begin
    if (strb.loadMode) modeQ <= |(cmdFeature & SEL_MASK);
  end
  assign modePd = modeQ;

  assign destructive = isDestructive(cmdOpcode);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      execIssue  <= 1'b0;
      execOpcode <= '0;
    end else begin
      execIssue <= strb.issue;
      if (strb.issue) execOpcode <= cmdOpcode;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      statusReg <= STAT_READY;
      errorReg  <= ERR_NONE;
    end else if (strb.setReject) begin
      statusReg <= STAT_REJECT;
      errorReg  <= ERR_ABORT;
    end else if (strb.setBusy) begin
      statusReg <= STAT_BUSY;
      errorReg  <= ERR_NONE;
    end else if (strb.setOk) begin
      statusReg <= STAT_READY;
      errorReg  <= ERR_NONE;
    end
  end
endmodule

// File: rtl/wpgate_ctrl.sv
module wpgate_ctrl
  import wpgate_pkg::*;
#(
  parameter logic [OP_W-1:0] CFG_OPCODE = 8'h8B
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            cmdValid,
  input  logic [OP_W-1:0] cmdOpcode,
  input  logic            execBusy,
  input  logic            execDone,
  input  logic            pinAsserted,
  input  logic            modePd,
  input  logic            destructive,
  output gateStrobe_t     strb,
  output logic            cmdReady,
  output logic            lockedOut
);
  gateState_t state, stateNext;
  logic lockNow;

  assign lockNow = modePd && pinAsserted;

  always_comb begin
    stateNext = state;
    strb = '0;
    case (state)
      ST_IDLE: begin
        if (lockNow) begin
          stateNext = ST_LOCK;
        end else if (cmdValid && !execBusy) begin
          if (cmdOpcode == CFG_OPCODE) begin
            strb.loadMode = 1'b1;
            strb.setOk = 1'b1;
          end else if (!modePd && pinAsserted && destructive) begin
            strb.setReject = 1'b1;
          end else begin
            strb.issue = 1'b1;
            strb.setBusy = 1'b1;
            stateNext = ST_EXEC;
          end
        end
      end
      ST_EXEC: begin
        if (execDone) begin
          strb.setOk = 1'b1;
          stateNext = lockNow ? ST_LOCK : ST_IDLE;
        end
      end
      ST_LOCK: stateNext = ST_LOCK;
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  assign cmdReady  = (state == ST_IDLE) && !lockNow && !execBusy;
  assign lockedOut = (state == ST_LOCK);
endmodule

// File: rtl/wpgate_top.sv
module wpgate_top
  import wpgate_pkg::*;
#(
  parameter logic [OP_W-1:0] CFG_OPCODE = 8'h8B,
  parameter int CFG_SEL_BIT = 0,
  parameter bit MODE_INIT = 1'b0,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             porRstN,
  input  logic             hwRstN,
  input  logic             pinN,
  input  logic             cmdValid,
  input  logic [OP_W-1:0]  cmdOpcode,
  input  logic [OP_W-1:0]  cmdFeature,
  output logic             cmdReady,
  output logic             execIssue,
  output logic [OP_W-1:0]  execOpcode,
  input  logic             execBusy,
  input  logic             execDone,
  output logic [REG_W-1:0] statusReg,
  output logic [REG_W-1:0] errorReg,
  output logic             lockedOut
);
  logic rstN;
  logic pinAsserted, modePd, destructive;
  gateStrobe_t strb;

  assign rstN = porRstN & hwRstN;

  wpgate_ctrl #(.CFG_OPCODE(CFG_OPCODE)) u_ctrl (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOpcode(cmdOpcode),
    .execBusy(execBusy), .execDone(execDone), .pinAsserted(pinAsserted),
    .modePd(modePd), .destructive(destructive), .strb(strb),
    .cmdReady(cmdReady), .lockedOut(lockedOut)
  );

  wpgate_dp #(.CFG_SEL_BIT(CFG_SEL_BIT), .MODE_INIT(MODE_INIT),
              .SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk(clk), .rstN(rstN), .pinN(pinN), .cmdOpcode(cmdOpcode),
    .cmdFeature(cmdFeature), .strb(strb), .pinAsserted(pinAsserted),
    .modePd(modePd), .destructive(destructive), .execIssue(execIssue),
    .execOpcode(execOpcode), .statusReg(statusReg), .errorReg(errorReg)
  );
endmodule

// File: rtl/wpgate_chk.sv
module wpgate_chk (
  input logic       clk,
  input logic       porRstN,
  input logic       hwRstN,
  input logic       cmdReady,
  input logic       execBusy,
  input logic       execIssue,
  input logic       lockedOut,
  input logic [7:0] statusReg,
  input logic [7:0] errorReg
);
  logic rstN;
  assign rstN = porRstN & hwRstN;

  AST_REJECT_PAIR: assert property (@(posedge clk) disable iff (!rstN)
    statusReg == 8'h51 |-> errorReg == 8'h04); // R1
  AST_ISSUE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    execIssue |=> !execIssue); // R2
  AST_ISSUE_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    execIssue |-> statusReg == 8'h80); // R6
  AST_BUSY_GATE: assert property (@(posedge clk) disable iff (!rstN)
    execBusy |-> !cmdReady); // R6
  AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    lockedOut |=> lockedOut); // R7
  AST_LOCK_SILENT: assert property (@(posedge clk) disable iff (!rstN)
    lockedOut |-> (!execIssue && !cmdReady)); // R8
endmodule

bind wpgate_top wpgate_chk u_chk (.*);

// File: tb/tb_wpgate_top.sv
module tb_wpgate_top;
  localparam logic [7:0] CFG_OP = 8'h8B;

  logic clk = 1'b0;
  logic porRstN = 1'b0, hwRstN = 1'b1, pinN = 1'b1;
  logic cmdValid = 1'b0, execBusy = 1'b0, execDone = 1'b0;
  logic [7:0] cmdOpcode = '0, cmdFeature = '0;
  logic cmdReady, execIssue, lockedOut;
  logic [7:0] execOpcode, statusReg, errorReg;

  int testsRun = 0, testsFailed = 0;
  bit modelPd = 1'b0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  wpgate_top dut (.*);

  function automatic bit isDest(input logic [7:0] op);
    return op inside {8'hC0, 8'h50, 8'hCA, 8'h32, 8'hC5, 8'hCD, 8'h30, 8'h31, 8'h38, 8'h3C};
  endfunction

  function automatic logic [7:0] destAt(input int i);
    logic [7:0] tbl [10] = '{8'hC0, 8'h50, 8'hCA, 8'h32, 8'hC5, 8'hCD, 8'h30, 8'h31, 8'h38, 8'h3C};
    return tbl[i];
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    testsRun++;
    if (!ok) begin
      testsFailed++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic setPin(input logic lvl);
    pinN = lvl;
    repeat (3) @(negedge clk);
  endtask

  task automatic pulseReset(input bit por);
    @(negedge clk);
    if (por) porRstN = 1'b0; else hwRstN = 1'b0;
    repeat (3) @(negedge clk);
    porRstN = 1'b1; hwRstN = 1'b1;
    @(negedge clk);
  endtask

  task automatic sendCmd(input logic [7:0] op, input logic [7:0] feat, input string tag);
    bit expRej, expFwd;
    int wait0 = 0;
    while (!cmdReady && wait0 < 50) begin @(negedge clk); wait0++; end
    expRej = (op != CFG_OP) && !modelPd && (pinN == 1'b0) && isDest(op);
    expFwd = (op != CFG_OP) && !expRej;
    cmdValid = 1'b1; cmdOpcode = op; cmdFeature = feat;
    @(negedge clk);
    cmdValid = 1'b0;
    if (expRej) begin
      chk(!execIssue && statusReg == 8'h51 && errorReg == 8'h04, tag,
          {8'(execIssue), 8'h00, statusReg, errorReg}, 32'h0000_5104);
    end else if (expFwd) begin
      chk(execIssue && execOpcode == op && statusReg == 8'h80, tag,
          {8'(execIssue), execOpcode, statusReg, 8'h00}, {8'h01, op, 8'h80, 8'h00});
      execBusy = 1'b1;
      repeat (1 + $urandom % 4) @(negedge clk);
      chk(!execIssue && statusReg == 8'h80, "R6 busy status", {8'(execIssue), statusReg}, 32'h80);
      execDone = 1'b1;
      @(negedge clk);
      execDone = 1'b0; execBusy = 1'b0;
      chk(statusReg == 8'h50 && errorReg == 8'h00, "R6 completion",
          {statusReg, errorReg}, 32'h5000);
    end else begin
      chk(!execIssue && statusReg == 8'h50 && errorReg == 8'h00, "R4 config",
          {8'(execIssue), statusReg, errorReg}, 32'h5000);
      modelPd = feat[0];
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      testsFailed++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    porRstN = 1'b1;
    @(negedge clk);
    // R10 reset state
    chk(statusReg == 8'h50 && errorReg == 8'h00, "R10 status", {statusReg, errorReg}, 32'h5000);
    chk(!execIssue && !lockedOut && cmdReady, "R10 flags",
        {execIssue, lockedOut, cmdReady}, 3'b001);

    // R1 every destructive opcode refused under write protect
    setPin(1'b0);
    for (int i = 0; i < 10; i++) sendCmd(destAt(i), 8'h00, "R1 reject");
    // R2 non-destructive pass-through with pin low
    sendCmd(8'h20, 8'h00, "R2 forward");
    sendCmd(8'hEC, 8'h00, "R2 forward");
    // R3 destructive forwarded with pin high
    setPin(1'b1);
    for (int i = 0; i < 10; i++) sendCmd(destAt(i), 8'h00, "R3 forward");

    // Random mix in write-protect mode
    for (int n = 0; n < 150; n++) begin
      logic [7:0] op;
      if ($urandom % 3 == 0) setPin(logic'($urandom % 2));
      if ($urandom % 2 == 0) op = destAt($urandom % 10);
      else begin
        op = 8'($urandom);
        if (op == CFG_OP) op = 8'h20;
      end
      sendCmd(op, 8'h00, isDest(op) ? "R1 random" : "R2 random");
    end

    // R5 write-protect role survives hardware reset
    setPin(1'b0);
    pulseReset(1'b0);
    chk(!lockedOut, "R5 wp not locked", 32'(lockedOut), 32'h0);
    sendCmd(8'hCA, 8'h00, "R5 wp kept");

    // R4 select power-down, then R5 across power-on reset
    setPin(1'b1);
    sendCmd(CFG_OP, 8'h01, "R4 select pd");
    pulseReset(1'b1);
    setPin(1'b0);
    chk(lockedOut && !cmdReady, "R5 pd kept", {lockedOut, cmdReady}, 2'b10);
    setPin(1'b1);
    pulseReset(1'b0);
    chk(!lockedOut && cmdReady, "R9 unlock", {lockedOut, cmdReady}, 2'b01);

    // R7 pin drops mid-command
    cmdValid = 1'b1; cmdOpcode = 8'h20;
    @(negedge clk);
    cmdValid = 1'b0;
    chk(execIssue, "R7 issue", 32'(execIssue), 32'h1);
    execBusy = 1'b1;
    pinN = 1'b0;
    repeat (4) @(negedge clk);
    chk(!lockedOut && statusReg == 8'h80, "R7 not aborted", {lockedOut, statusReg}, 9'h080);
    execDone = 1'b1;
    @(negedge clk);
    execDone = 1'b0; execBusy = 1'b0;
    chk(lockedOut && statusReg == 8'h50, "R7 lock after done", {lockedOut, statusReg}, 9'h150);

    // R8 commands dropped while locked
    cmdValid = 1'b1; cmdOpcode = 8'hEC;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      chk(!execIssue && !cmdReady && lockedOut, "R8 dropped",
          {execIssue, cmdReady, lockedOut}, 3'b001);
    end
    cmdValid = 1'b0;

    // R9 reset with pin still low relocks
    @(negedge clk);
    hwRstN = 1'b0;
    repeat (3) @(negedge clk);
    hwRstN = 1'b1;
    repeat (2) @(negedge clk);
    chk(lockedOut, "R9 relock", 32'(lockedOut), 32'h1);
    setPin(1'b1);
    pulseReset(1'b1);
    chk(!lockedOut && cmdReady, "R9 por unlock", {lockedOut, cmdReady}, 2'b01);

    // R4 back to write-protect
    sendCmd(CFG_OP, 8'h00, "R4 select wp");
    setPin(1'b0);
    sendCmd(8'h3C, 8'h00, "R4 wp active");
    chk(!lockedOut, "R4 no lock in wp", 32'(lockedOut), 32'h0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end
endmodule